// File: doc/BRIEF.md
# Write-Only Two-Wire Bias DAC Command Writer

This block sends one complete three-byte write to a bias-voltage DAC over a two-wire bus that is only ever driven and never read back. The two bus lines are not real pins: they are two bits of an 8-bit power control register. Each bus edge is therefore produced as a whole-register write request to a downstream serial port. The request carries the register address and an 8-bit value. That value merges the current clock and data levels with the caller's other power-control bits, which must keep their state. After every accepted write the block waits a fixed settle time before it issues the next one.

A caller pulses `start_i` with the DAC code on `dac_val_i` and the power-control bits to keep on `base_i`. Both are captured on the start cycle. The block then emits the following writes, 87 in all:

- a start condition;
- the device byte 0x9C, then an acknowledge slot;
- the sub-address byte 0x00, then an acknowledge slot;
- the DAC code, then an acknowledge slot;
- a stop condition.

Each acknowledge slot is one clock pulse with the data line held low. Nothing is sampled in that slot.

The controller has four states:

- IDLE: waits for a start request.
- ISSUE: holds a write request until `wr_ready_i`.
- SETTLE: counts the settle time.
- DONE: raises the done pulse for one cycle.

It has five transitions:

- IDLE→ISSUE on `start_i`.
- ISSUE→SETTLE on handshake.
- SETTLE→ISSUE on expiry when more writes remain.
- SETTLE→DONE on expiry after the final stop write.
- DONE→IDLE unconditionally.

A separate step sequencer tracks three things: the segment (start, bits, stop), the phase within a three-write group, and the bit and slot indices.

Top module: `dacw_writer`

## Requirements
- R1: After reset `wr_valid_o`, `busy_o` and `done_o` are low.
- R2: Every write request uses address 3. Data bits 7..2 equal `base_i` bits 7..2 as captured at start.
- R3: The start condition is three writes whose {bit1 data, bit0 clock} values are 2'b11, 2'b01 and 2'b00, in that order.
- R4: Each data bit is three writes with the bit value on bit 1 and the clock on bit 0: clock 0, then 1, then 0. The most significant bit goes first.
- R5: One transaction is exactly 87 writes, in this order: start, 0x9C, ack, 0x00, ack, DAC code, ack, stop.
- R6: An acknowledge slot is one bit-group of three writes with data 0. No bus input is sampled.
- R7: The stop condition is three writes with {data, clock} values 2'b00, 2'b01 and 2'b11, in that order.
- R8: A write request that is not accepted stays valid with unchanged address and data until `wr_ready_i` is high.
- R9: After an accepted write, no request is presented for `SETTLE_CYC` cycles. With `wr_ready_i` held high, accepted writes are exactly `SETTLE_CYC`+1 cycles apart.
- R10: `done_o` pulses for exactly one cycle after the settle time of the last stop write, and `busy_o` is low after it.
- R11: A start request while busy has no effect. Changing `dac_val_i` or `base_i` during a transaction does not alter its writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request strobe |
| dac_val_i | input | 8 | DAC code for the third byte |
| base_i | input | REG_W | Power-control bits to preserve (bits 1..0 replaced) |
| wr_valid_o | output | 1 | Register write request valid |
| wr_addr_o | output | ADDR_W | Register address of the write |
| wr_data_o | output | REG_W | Register value of the write |
| wr_ready_i | input | 1 | Downstream port accepts the write |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked on every cycle by the assertions:

- a stalled request keeps its data;
- no request directly follows an accepted one;
- the done pulse lasts one cycle and leaves the block idle;
- the settle counter and the sequencer's phase and bit indices stay in range;
- a restart attempt never drops the busy flag.

Other properties only the bench's scenarios can show, because they need the whole write stream:

- the clock/data pattern of the start, data bits, acknowledge slots and stop;
- the MSB-first byte order, and the total of 87 writes;
- preservation of the upper register bits;
- the exact spacing between accepted writes;
- that a second start and changed inputs during a transaction leave the stream untouched.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
    // Bus line positions inside the power control register
    localparam int LINE_CLK_POS = 0;
    localparam int LINE_DAT_POS = 1;

    // Fixed bytes of the DAC write
    localparam logic [7:0] DEV_BYTE = 8'h9C;
    localparam logic [7:0] SUB_BYTE = 8'h00;

    // Number of byte/ack slots in the bits segment
    localparam int NUM_SLOTS = 6;

    typedef enum logic [1:0] {
        SEG_START,
        SEG_BITS,
        SEG_STOP
    } seg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_SETTLE,
        ST_DONE
    } fsm_t;
endpackage

// File: rtl/dacw_settle.sv
module dacw_settle #(
    parameter int SETTLE_CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CW-1:0] RELOAD = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= RELOAD);
endmodule

// File: rtl/dacw_step.sv
module dacw_step
    import dacw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_i,
    input  logic       adv_i,
    input  logic [7:0] dac_val_i,
    output logic       scl_o,
    output logic       sda_o,
    output logic       last_o
);
    seg_t       seg_q;
    logic [1:0] ph_q;
    logic [2:0] bit_q;
    logic [2:0] slot_q;

    logic       is_ack;
    logic [7:0] cur_byte;

    assign is_ack = slot_q[0];

    always_comb begin
        unique case (slot_q[2:1])
            2'd0:    cur_byte = DEV_BYTE;
            2'd1:    cur_byte = SUB_BYTE;
            default: cur_byte = dac_val_i;
        endcase
    end

    // Line levels for the current write
    always_comb begin
        scl_o = 1'b0;
        sda_o = 1'b0;
        unique case (seg_q)
            SEG_START: begin
                scl_o = (ph_q != 2'd2);
                sda_o = (ph_q == 2'd0);
            end
            SEG_BITS: begin
                scl_o = (ph_q == 2'd1);
                sda_o = is_ack ? 1'b0 : cur_byte[3'd7 - bit_q];
            end
            default: begin
                scl_o = (ph_q != 2'd0);
                sda_o = (ph_q == 2'd2);
            end
        endcase
    end

    assign last_o = (seg_q == SEG_STOP) && (ph_q == 2'd2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q  <= SEG_START;
            ph_q   <= '0;
            bit_q  <= '0;
            slot_q <= '0;
        end else if (init_i) begin
            seg_q  <= SEG_START;
            ph_q   <= '0;
            bit_q  <= '0;
            slot_q <= '0;
        end else if (adv_i) begin
            if (ph_q != 2'd2) begin
                ph_q <= ph_q + 1'b1;
            end else begin
                ph_q <= '0;
                unique case (seg_q)
                    SEG_START: begin
                        seg_q  <= SEG_BITS;
                        bit_q  <= '0;
                        slot_q <= '0;
                    end
                    SEG_BITS: begin
                        if (is_ack || bit_q == 3'd7) begin
                            bit_q <= '0;
                            if (slot_q == 3'(NUM_SLOTS - 1)) begin
                                seg_q <= SEG_STOP;
                            end else begin
                                slot_q <= slot_q + 1'b1;
                            end
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                    default: seg_q <= SEG_STOP;
                endcase
            end
        end
    end

    // R4
    ph_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q != 2'd3);
    // R6
    ack_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_q == SEG_BITS && is_ack) |-> bit_q == 3'd0);
    // R5
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q < 3'(NUM_SLOTS));
endmodule

// File: rtl/dacw_writer.sv
module dacw_writer
    import dacw_pkg::*;
#(
    parameter int REG_W      = 8,
    parameter int ADDR_W     = 3,
    parameter int PWR_ADDR   = 3,
    parameter int SETTLE_CYC = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        dac_val_i,
    input  logic [REG_W-1:0]  base_i,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [REG_W-1:0]  wr_data_o,
    input  logic              wr_ready_i,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [REG_W-1:0] LINE_MASK =
        (REG_W'(1) << LINE_CLK_POS) | (REG_W'(1) << LINE_DAT_POS);

    fsm_t             state_q, state_d;
    logic [REG_W-1:0] base_q;
    logic [7:0]       val_q;
    logic             scl, sda, last_wr, expired;
    logic             accept, load_settle, adv_step;

    assign accept      = (state_q == ST_IDLE) && start_i;
    assign load_settle = (state_q == ST_ISSUE) && wr_ready_i;
    assign adv_step    = (state_q == ST_SETTLE) && expired && !last_wr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_ISSUE;
            ST_ISSUE:  if (wr_ready_i) state_d = ST_SETTLE;
            ST_SETTLE: if (expired) state_d = last_wr ? ST_DONE : ST_ISSUE;
            ST_DONE:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            val_q  <= '0;
        end else if (accept) begin
            base_q <= base_i;
            val_q  <= dac_val_i;
        end
    end

    dacw_step u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_i   (accept),
        .adv_i    (adv_step),
        .dac_val_i(val_q),
        .scl_o    (scl),
        .sda_o    (sda),
        .last_o   (last_wr)
    );

    dacw_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_settle),
        .expired_o(expired)
    );

    always_comb begin
        wr_valid_o = (state_q == ST_ISSUE);
        wr_addr_o  = ADDR_W'(PWR_ADDR);
        wr_data_o  = (base_q & ~LINE_MASK)
                   | (REG_W'(scl) << LINE_CLK_POS)
                   | (REG_W'(sda) << LINE_DAT_POS);
        busy_o     = (state_q != ST_IDLE);
        done_o     = (state_q == ST_DONE);
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_data_o)));
    // R9
    settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_ready_i) |=> !wr_valid_o);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wr_valid_o);
    // R11
    busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o);
endmodule

// File: tb/sim_dacw_writer.sv
module sim_dacw_writer;
    localparam int S  = 4;
    localparam int NW = 87;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] dac_val_i = '0;
    logic [7:0] base_i = '0;
    logic       wr_ready_i = 1'b1;
    logic       wr_valid_o, busy_o, done_o;
    logic [2:0] wr_addr_o;
    logic [7:0] wr_data_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dacw_writer #(.REG_W(8), .ADDR_W(3), .PWR_ADDR(3), .SETTLE_CYC(S)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dac_val_i(dac_val_i),
        .base_i(base_i), .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .wr_ready_i(wr_ready_i), .busy_o(busy_o),
        .done_o(done_o)
    );

    // monitor state
    logic [7:0] log_d [0:127];
    logic [2:0] log_a [0:127];
    int log_cnt = 0, ncyc = 0, last_hs = -1, gap_min = 1 << 30, gap_max = 0;
    int done_cnt = 0, done_after = -1, stall_err = 0;
    logic prev_stall = 1'b0;
    logic [7:0] prev_d = '0;
    logic stall_mode = 1'b0;
    int rdy_pat = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected {data, clock} for write number idx
    function automatic logic [1:0] exp_bits(input int idx, input logic [7:0] v);
        int slot, ph, bi;
        logic [7:0] b;
        logic dat;
        if (idx < 3) return (idx == 0) ? 2'b11 : (idx == 1) ? 2'b01 : 2'b00;
        if (idx >= 84) return (idx == 84) ? 2'b00 : (idx == 85) ? 2'b01 : 2'b11;
        slot = (idx - 3) / 3;
        ph   = (idx - 3) % 3;
        if (slot == 8 || slot == 17 || slot == 26) begin
            dat = 1'b0;
        end else begin
            b  = (slot < 8) ? 8'h9C : (slot < 17) ? 8'h00 : v;
            bi = (slot < 8) ? slot : (slot < 17) ? slot - 9 : slot - 18;
            dat = b[7 - bi];
        end
        return {dat, (ph == 1)};
    endfunction

    function automatic string region_tag(input int idx);
        int slot;
        if (idx < 3) return "R3";
        if (idx >= 84) return "R7";
        slot = (idx - 3) / 3;
        if (slot == 8 || slot == 17 || slot == 26) return "R6";
        return "R4";
    endfunction

    always @(posedge clk) begin
        #1;
        rdy_pat++;
        wr_ready_i = stall_mode ? ((rdy_pat % 3) == 0) : 1'b1;
    end

    always @(negedge clk) begin
        ncyc++;
        if (prev_stall && !(wr_valid_o && wr_data_o == prev_d)) stall_err++;
        prev_stall = wr_valid_o && !wr_ready_i;
        prev_d     = wr_data_o;
        if (wr_valid_o && wr_ready_i) begin
            if (log_cnt < 128) begin
                log_d[log_cnt] = wr_data_o;
                log_a[log_cnt] = wr_addr_o;
            end
            log_cnt++;
            if (last_hs >= 0) begin
                if (ncyc - last_hs < gap_min) gap_min = ncyc - last_hs;
                if (ncyc - last_hs > gap_max) gap_max = ncyc - last_hs;
            end
            last_hs = ncyc;
        end
        if (done_o) begin
            done_cnt++;
            done_after = log_cnt;
        end
    end

    task automatic clear_log();
        log_cnt = 0; last_hs = -1; gap_min = 1 << 30; gap_max = 0;
        done_cnt = 0; done_after = -1; stall_err = 0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!wr_valid_o, "R1 wr_valid", int'(wr_valid_o), 0);
        chk(!busy_o, "R1 busy", int'(busy_o), 0);
        chk(!done_o, "R1 done", int'(done_o), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic t_txn(input logic [7:0] val, input logic [7:0] base,
                         input bit stall, input bit inject);
        int waited;
        int e_r2, e_r3, e_r4, e_r6, e_r7;
        logic [7:0] dec;
        @(posedge clk); #1;
        stall_mode = stall;
        clear_log();
        dac_val_i = val; base_i = base; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        if (inject) begin
            repeat (20) @(posedge clk);
            #1;
            dac_val_i = ~val; base_i = ~base; start_i = 1'b1;
            @(posedge clk); #1;
            start_i = 1'b0;
            repeat (100) @(posedge clk);
            #1;
            start_i = 1'b1;
            @(posedge clk); #1;
            start_i = 1'b0;
        end
        waited = 0;
        while (done_cnt == 0 && waited < 5000) begin
            @(posedge clk);
            waited++;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(log_cnt == NW, "R5 write count", log_cnt, NW);
        e_r2 = 0; e_r3 = 0; e_r4 = 0; e_r6 = 0; e_r7 = 0;
        dec = '0;
        for (int i = 0; i < NW && i < log_cnt; i++) begin
            if (log_a[i] != 3'd3 || log_d[i][7:2] != base[7:2]) e_r2++;
            if (log_d[i][1:0] != exp_bits(i, val)) begin
                case (region_tag(i))
                    "R3": e_r3++;
                    "R7": e_r7++;
                    "R6": e_r6++;
                    default: e_r4++;
                endcase
                $display("FAIL %s write %0d actual=%0d expected=%0d",
                         region_tag(i), i, log_d[i][1:0], exp_bits(i, val));
            end
            if (i >= 57 && i < 81 && ((i - 3) % 3) == 1) dec = {dec[6:0], log_d[i][1]};
        end
        chk(e_r2 == 0, "R2 addr/upper bits mismatches", e_r2, 0);
        chk(e_r3 == 0, "R3 start mismatches", e_r3, 0);
        chk(e_r4 == 0, "R4 bit mismatches", e_r4, 0);
        chk(e_r6 == 0, "R6 ack mismatches", e_r6, 0);
        chk(e_r7 == 0, "R7 stop mismatches", e_r7, 0);
        chk(dec == val, "R5 decoded DAC byte", int'(dec), int'(val));
        chk(gap_min >= S + 1, "R9 min gap", gap_min, S + 1);
        if (!stall) chk(gap_max == S + 1, "R9 exact gap", gap_max, S + 1);
        else chk(stall_err == 0, "R8 stalled request stability", stall_err, 0);
        chk(done_cnt == 1, "R10 done pulses", done_cnt, 1);
        chk(done_after == NW, "R10 done after last write", done_after, NW);
        chk(!busy_o, "R10 busy after done", int'(busy_o), 0);
        if (inject) chk(log_cnt == NW && dec == val && e_r2 == 0,
                        "R11 restart ignored", log_cnt, NW);
    endtask

    initial begin
        t_reset();
        t_txn(8'h7D, 8'hA4, 1'b0, 1'b0);
        t_txn(8'h00, 8'h5F, 1'b0, 1'b0);
        t_txn(8'hFF, 8'h10, 1'b1, 1'b0);
        t_txn(8'hA5, 8'hC3, 1'b0, 1'b1);
        t_txn(8'h81, 8'hFF, 1'b1, 1'b1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule